// File: doc/BRIEF.md
# Zero-Run Output Gate for a Stereo Sample Path

This block sits between an audio deserializer and a digital-to-analog converter core and decides, on every bit-clock cycle, whether the converter sees the incoming sample words or the midscale code. It watches all channels of the current sample and counts consecutive bit-clock cycles during which every channel is all-zero. When zero detection is enabled and the run reaches a programmable threshold, the output is pulled to midscale at once. Two higher-priority controls can force midscale regardless of the data: the active-low reset, and an output-off override.

The heart of the block is a three-state run tracker. `ST_LIVE` means the last sample had data. `ST_RUN` means a zero run is being counted and is still below the threshold. `ST_HELD` means the threshold has been reached. The transitions are:
- LIVE→RUN on a zero sample.
- LIVE→HELD on a zero sample when the threshold is one.
- RUN→RUN on a zero sample below the threshold.
- RUN→HELD when the count reaches the threshold.
- RUN→LIVE or HELD→LIVE on any non-zero sample.
- HELD→HELD on a zero sample, with the counter saturated.

A priority arbiter combines this tracker with the reset, override and enable inputs. It exposes both a force flag and a two-bit cause code. A per-channel gate replaces forced samples with the two's-complement zero word.

Top module: `zero_run_gate`

## Requirements
- R1: While `rst_n` is low, `o_force` is 1, `o_cause` is 2'b01 and `o_data` is all zero whatever `i_data` holds. Reset also clears the zero-run count, so after release a full `ZERO_RUN` zero cycles are again needed before zero forcing.
- R2: With `rst_n` high and `i_out_off` high, `o_force` is 1, `o_cause` is 2'b10 and `o_data` is zero for any input data.
- R3: With `i_zd_en` high, once `ZERO_RUN` consecutive cycles of all-zero input have been clocked in, `o_force` is 1 with `o_cause` 2'b11 from the next cycle. After only `ZERO_RUN-1` such cycles it is still 0.
- R4: With `i_zd_en` low and `i_out_off` low, `o_force` stays 0 for a zero run of any length.
- R5: When `o_force` is 0, `o_data` equals `i_data` in the same cycle on every channel.
- R6: A non-zero sample returns the tracker to LIVE. If forcing was active, that sample is itself still forced, and forcing is released from the following cycle.
- R7: The run count saturates at `ZERO_RUN`, so zero forcing persists for a run several times longer than the threshold.
- R8: The priority is reset over output-off over zero detect. The cause code is 00 none, 01 reset, 10 output-off, 11 zero run.
- R9: The run is counted whatever the state of `i_zd_en` and `i_out_off`. Raising `i_zd_en` during a long zero run forces the output in that same cycle.
- R10: A sample counts as zero only if every bit of every channel is zero. One set bit in any channel breaks the run.
- R11: The forced word on each channel is the two's-complement zero code, with all bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, also forces midscale |
| i_data | input | CHANNELS*SAMPLE_W | Current sample words, channel 0 in the low bits |
| i_out_off | input | 1 | Output-off override, high forces midscale |
| i_zd_en | input | 1 | Zero-run forcing enable |
| o_force | output | 1 | High while the output is held at midscale |
| o_cause | output | 2 | Reason for forcing (see R8) |
| o_data | output | CHANNELS*SAMPLE_W | Gated sample words |

## Verification
The bench builds the block with `ZERO_RUN` set to 20, `SAMPLE_W` set to 8 and `CHANNELS` set to 2. A short threshold puts the exact threshold edge, the saturated hold over runs of three times the threshold, and the release cycle within a few dozen cycles. The same settings make long random runs that cross the threshold many times affordable. Two narrow channels keep the single-bit run breakers in either channel easy to place.

// File: rtl/zrg_pkg.sv
package zrg_pkg;

    typedef enum logic [1:0] {
        ST_LIVE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_RESET = 2'b01,
        CAUSE_OFF   = 2'b10,
        CAUSE_ZERO  = 2'b11
    } force_cause_t;

endpackage

// File: rtl/zrg_scan.sv
module zrg_scan #(
    parameter int SAMPLE_W = 18,
    parameter int CHANNELS = 2
) (
    input  logic [CHANNELS*SAMPLE_W-1:0] i_data,
    output logic                         o_zero
);
    logic [CHANNELS-1:0] ch_zero;

    genvar g;
    generate
        for (g = 0; g < CHANNELS; g++) begin : g_ch
            assign ch_zero[g] = (i_data[g*SAMPLE_W +: SAMPLE_W] == '0);
        end
    endgenerate

    assign o_zero = &ch_zero;
endmodule

// File: rtl/zrg_run_fsm.sv
module zrg_run_fsm
    import zrg_pkg::*;
#(
    parameter int ZERO_RUN = 65536
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic i_zero,
    output logic o_hit
);
    localparam int CNT_W = $clog2(ZERO_RUN + 1);
    localparam logic [CNT_W-1:0] TH_V = CNT_W'(ZERO_RUN);

    run_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_LIVE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_LIVE: begin
                if (i_zero) begin
                    cnt_nx = CNT_W'(1);
                    st_nx  = (TH_V == CNT_W'(1)) ? ST_HELD : ST_RUN;
                end else begin
                    cnt_nx = '0;
                end
            end
            ST_RUN: begin
                if (!i_zero) begin
                    st_nx  = ST_LIVE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                    if (cnt + 1'b1 == TH_V) st_nx = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!i_zero) begin
                    st_nx  = ST_LIVE;
                    cnt_nx = '0;
                end
            end
            default: begin
                st_nx  = ST_LIVE;
                cnt_nx = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        o_hit = (st == ST_HELD);
    end

    // R7
    cnt_sat_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        cnt <= TH_V);

    // R6
    clr_on_data_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !i_zero |=> (st == ST_LIVE && cnt == '0));

    // R3
    reach_held_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (st == ST_RUN && i_zero && cnt == TH_V - 1'b1) |=> (st == ST_HELD));

    // R7
    stay_held_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (st == ST_HELD && i_zero) |=> (st == ST_HELD));
endmodule

// File: rtl/zrg_arbiter.sv
module zrg_arbiter
    import zrg_pkg::*;
(
    input  logic       rst_n,
    input  logic       i_out_off,
    input  logic       i_zd_en,
    input  logic       i_hit,
    output logic       o_force,
    output logic [1:0] o_cause
);
    force_cause_t cause;

    always_comb begin
        if (!rst_n)                 cause = CAUSE_RESET;
        else if (i_out_off)         cause = CAUSE_OFF;
        else if (i_zd_en && i_hit)  cause = CAUSE_ZERO;
        else                        cause = CAUSE_NONE;
    end

    assign o_cause = cause;
    assign o_force = (cause != CAUSE_NONE);
endmodule

// File: rtl/zrg_gate.sv
module zrg_gate #(
    parameter int SAMPLE_W = 18,
    parameter int CHANNELS = 2
) (
    input  logic                         i_force,
    input  logic [CHANNELS*SAMPLE_W-1:0] i_data,
    output logic [CHANNELS*SAMPLE_W-1:0] o_data
);
    localparam logic [SAMPLE_W-1:0] MID_CODE = '0;

    genvar g;
    generate
        for (g = 0; g < CHANNELS; g++) begin : g_ch
            assign o_data[g*SAMPLE_W +: SAMPLE_W] =
                i_force ? MID_CODE : i_data[g*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate
endmodule

// File: rtl/zero_run_gate.sv
module zero_run_gate #(
    parameter int ZERO_RUN = 65536,
    parameter int SAMPLE_W = 18,
    parameter int CHANNELS = 2
) (
    input  logic                         clk_bit,
    input  logic                         rst_n,
    input  logic [CHANNELS*SAMPLE_W-1:0] i_data,
    input  logic                         i_out_off,
    input  logic                         i_zd_en,
    output logic                         o_force,
    output logic [1:0]                   o_cause,
    output logic [CHANNELS*SAMPLE_W-1:0] o_data
);
    localparam int BUS_W = CHANNELS * SAMPLE_W;

    logic is_zero;
    logic run_hit;

    zrg_scan #(.SAMPLE_W(SAMPLE_W), .CHANNELS(CHANNELS)) scan_i (
        .i_data (i_data),
        .o_zero (is_zero)
    );

    zrg_run_fsm #(.ZERO_RUN(ZERO_RUN)) fsm_i (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .i_zero  (is_zero),
        .o_hit   (run_hit)
    );

    zrg_arbiter arb_i (
        .rst_n     (rst_n),
        .i_out_off (i_out_off),
        .i_zd_en   (i_zd_en),
        .i_hit     (run_hit),
        .o_force   (o_force),
        .o_cause   (o_cause)
    );

    zrg_gate #(.SAMPLE_W(SAMPLE_W), .CHANNELS(CHANNELS)) gate_i (
        .i_force (o_force),
        .i_data  (i_data),
        .o_data  (o_data)
    );

    // R2
    off_mutes_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        i_out_off |-> (o_data == BUS_W'(0) && o_cause == 2'b10));

    // R4
    no_auto_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!i_zd_en && !i_out_off) |-> !o_force);

    // R5
    pass_thru_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !o_force |-> (o_data == i_data));

    // R6
    release_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (i_data != BUS_W'(0) && !i_out_off) |=> !$past(i_out_off) && !i_out_off |-> !o_force);
endmodule

// File: tb/zero_run_gate_tb.sv
module zero_run_gate_tb_top;
    localparam int TH  = 20;
    localparam int SW  = 8;
    localparam int NC  = 2;
    localparam int BW  = SW * NC;

    logic          clk_bit = 1'b0;
    logic          rst_n   = 1'b0;
    logic [BW-1:0] i_data  = '0;
    logic          i_out_off = 1'b0;
    logic          i_zd_en   = 1'b0;
    logic          o_force;
    logic [1:0]    o_cause;
    logic [BW-1:0] o_data;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;
    string phase   = "R1";
    int    m_cnt   = 0;

    always #2.5 clk_bit = ~clk_bit;

    zero_run_gate #(.ZERO_RUN(TH), .SAMPLE_W(SW), .CHANNELS(NC)) dut_i (
        .clk_bit (clk_bit), .rst_n (rst_n), .i_data (i_data),
        .i_out_off (i_out_off), .i_zd_en (i_zd_en),
        .o_force (o_force), .o_cause (o_cause), .o_data (o_data)
    );

    // behavioural run-length model
    always @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n)            m_cnt <= 0;
        else if (i_data == 0)  m_cnt <= (m_cnt >= TH) ? TH : m_cnt + 1;
        else                   m_cnt <= 0;
    end

    function automatic logic [1:0] exp_cause();
        if (!rst_n)                      return 2'b01;
        if (i_out_off)                   return 2'b10;
        if (i_zd_en && m_cnt >= TH)      return 2'b11;
        return 2'b00;
    endfunction

    task automatic compare();
        logic [1:0]    ec = exp_cause();
        logic          ef = (ec != 2'b00);
        logic [BW-1:0] ed = ef ? '0 : i_data;
        vectors++;
        if (o_force !== ef || o_cause !== ec || o_data !== ed) begin
            fails++;
            $display("FAIL %s: force/cause/data got %b/%b/%h exp %b/%b/%h",
                     phase, o_force, o_cause, o_data, ef, ec, ed);
        end
    endtask

    task automatic step(input logic [BW-1:0] d, input logic off, input logic zd, input logic rn);
        @(negedge clk_bit);
        i_data = d; i_out_off = off; i_zd_en = zd; rst_n = rn;
        #1;
        compare();
    endtask

    task automatic chk(input string tag, input logic ef, input logic [1:0] ec);
        vectors++;
        if (o_force !== ef || o_cause !== ec) begin
            fails++;
            $display("FAIL %s: force/cause got %b/%b exp %b/%b", tag, o_force, o_cause, ef, ec);
        end
    endtask

    task automatic zeros(input int n, input logic off, input logic zd);
        for (int i = 0; i < n; i++) step('0, off, zd, 1'b1);
    endtask

    initial begin
        // R1: reset forces regardless of data
        phase = "R1";
        step(16'hA5C3, 1'b0, 1'b1, 1'b0);
        step(16'h0000, 1'b0, 1'b0, 1'b0);
        step(16'hFFFF, 1'b0, 1'b1, 1'b0);
        chk("R1", 1'b1, 2'b01);
        if (o_data !== '0) begin fails++; $display("FAIL R1: data %h exp 0000", o_data); end
        vectors++;

        // R5: pass-through
        phase = "R5";
        for (int i = 0; i < 10; i++) step(BW'($urandom) | 16'h0100, 1'b0, 1'b1, 1'b1);
        chk("R5", 1'b0, 2'b00);

        // R3: threshold edge
        phase = "R3";
        zeros(TH, 1'b0, 1'b1);
        chk("R3", 1'b0, 2'b00);
        step('0, 1'b0, 1'b1, 1'b1);
        chk("R3", 1'b1, 2'b11);

        // R7: saturation
        phase = "R7";
        zeros(3 * TH, 1'b0, 1'b1);
        chk("R7", 1'b1, 2'b11);

        // R6 / R11: non-zero sample still forced, released next cycle
        phase = "R6";
        step(16'hFFFF, 1'b0, 1'b1, 1'b1);
        chk("R6", 1'b1, 2'b11);
        vectors++;
        if (o_data !== '0) begin fails++; $display("FAIL R11: data %h exp 0000", o_data); end
        step(16'h1234, 1'b0, 1'b1, 1'b1);
        chk("R6", 1'b0, 2'b00);

        // R4: detection disabled
        phase = "R4";
        zeros(3 * TH, 1'b0, 1'b0);
        chk("R4", 1'b0, 2'b00);

        // R9: enabling during a long run forces at once
        phase = "R9";
        step('0, 1'b0, 1'b1, 1'b1);
        chk("R9", 1'b1, 2'b11);

        // R2 / R8: output-off override and priority
        phase = "R2";
        step('0, 1'b1, 1'b1, 1'b1);
        chk("R8", 1'b1, 2'b10);
        step(16'h7F01, 1'b1, 1'b0, 1'b1);
        chk("R2", 1'b1, 2'b10);
        phase = "R8";
        step(16'h7F01, 1'b1, 1'b1, 1'b0);
        chk("R8", 1'b1, 2'b01);

        // R1: reset clears the run count
        phase = "R1";
        step('0, 1'b0, 1'b1, 1'b1);
        zeros(TH - 2, 1'b0, 1'b1);
        step('0, 1'b0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1, 1'b0);
        zeros(TH, 1'b0, 1'b1);
        chk("R1", 1'b0, 2'b00);
        step('0, 1'b0, 1'b1, 1'b1);
        chk("R1", 1'b1, 2'b11);

        // R10: a single bit in either channel breaks the run
        phase = "R10";
        step(16'h8000, 1'b0, 1'b1, 1'b1);
        zeros(TH - 1, 1'b0, 1'b1);
        step(16'h0001, 1'b0, 1'b1, 1'b1);
        zeros(TH, 1'b0, 1'b1);
        chk("R10", 1'b0, 2'b00);
        step(16'h0100, 1'b0, 1'b1, 1'b1);
        zeros(TH, 1'b0, 1'b1);
        chk("R10", 1'b0, 2'b00);

        // mixed random traffic with long zero runs
        phase = "R8";
        for (int blk = 0; blk < 60; blk++) begin
            int len = 1 + ($urandom % (2 * TH));
            logic off = ($urandom % 8) == 0;
            logic zd  = ($urandom % 4) != 0;
            logic rn  = ($urandom % 20) != 0;
            if (($urandom % 3) == 0) begin
                for (int i = 0; i < 4; i++)
                    step(BW'($urandom), off, zd, rn);
            end else begin
                for (int i = 0; i < len; i++) step('0, off, zd, rn);
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule